// File: doc/BRIEF.md
# I2S Signal Retiming Delay Unit

This block sits between the I2S pads and the transmitter and receiver cores. It moves the bit clock, word select, serial data and a data-valid flag across on a fast reference clock, and it adds a programmable delay to each path. Software sets the delays through a 25-bit control word. How that word is written is outside this block.

Each signal coming in from the pads first passes through a two-stage synchronizer. The two stages capture on opposite edges of the reference clock, and a control bit chooses which edge captures first. After the synchronizer comes a delay line of selectable length. Together these give delays of 1.5 to 4.5 reference cycles in whole-cycle steps. Each signal leaving for the pads passes through a delay of 0 to 3 whole cycles. The bit clock delivered to the transmitter core can be inverted for use when the transmitter runs as a slave.

Top module: `i2s_retime`

## Requirements
- R1: While reset is asserted, and after it is released, every output is 0, provided all data inputs and the control word are 0.
- R2: An input path whose order bit is 0 (rising edge first) delivers a pad change to its core output 2c+3 half-cycles after the rising reference edge that first captures it, where c is its 2-bit delay code. The code fields are:
  - transmitter bit clock at bits 1:0;
  - transmitter word select at bits 3:2;
  - receiver bit clock at bits 5:4;
  - receiver word select at bits 7:6;
  - receiver data at bits 9:8.
- R3: Bit 20 selects the capture order of the two transmitter input paths. Bit 21 selects the capture order of the three receiver input paths. With the bit at 1, the first capture is on the falling edge and the delay is still 2c+3 half-cycles, counted from that falling edge.
- R4: The data-valid flag is an input path with its delay code at bits 23:22 and its capture order taken from bit 21, with the same timing as R2 and R3.
- R5: An output path with code k drives its pad output with the core input when k is 0. For k of 1 to 3 it drives the value the core input had at the rising edge k cycles earlier. The code fields are:
  - transmitter bit clock at bits 11:10;
  - transmitter word select at bits 13:12;
  - transmitter data at bits 15:14;
  - receiver word select at bits 17:16;
  - receiver bit clock at bits 19:18.
- R6: When bit 24 is 1, the transmitter bit clock delivered to the core is the inverse of its delayed pad value. The inversion takes effect at once and touches no other output.
- R7: A change of a delay code selects another tap of the running delay line. Samples already held in the line are kept, and none are cleared or reloaded.
- R8: The delay of a path depends only on its own code field and its own order bit. The other bits of the control word have no effect on it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref | input | 1 | Fast reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_word | input | 25 | Delay codes, capture order bits and inversion bit |
| pin_tx_bclk_i | input | 1 | Transmitter bit clock from pad |
| pin_tx_ws_i | input | 1 | Transmitter word select from pad |
| pin_rx_bclk_i | input | 1 | Receiver bit clock from pad |
| pin_rx_ws_i | input | 1 | Receiver word select from pad |
| pin_rx_sd_i | input | 1 | Receiver serial data from pad |
| dvalid_i | input | 1 | Data-valid flag before retiming |
| core_tx_bclk_o | output | 1 | Retimed, optionally inverted bit clock to transmitter |
| core_tx_ws_o | output | 1 | Retimed word select to transmitter |
| core_rx_bclk_o | output | 1 | Retimed bit clock to receiver |
| core_rx_ws_o | output | 1 | Retimed word select to receiver |
| core_rx_sd_o | output | 1 | Retimed serial data to receiver |
| dvalid_o | output | 1 | Retimed data-valid flag |
| core_tx_bclk_i | input | 1 | Transmitter bit clock from core |
| core_tx_ws_i | input | 1 | Transmitter word select from core |
| core_tx_sd_i | input | 1 | Transmitter serial data from core |
| core_rx_ws_i | input | 1 | Receiver word select from core |
| core_rx_bclk_i | input | 1 | Receiver bit clock from core |
| pin_tx_bclk_o | output | 1 | Delayed transmitter bit clock to pad |
| pin_tx_ws_o | output | 1 | Delayed transmitter word select to pad |
| pin_tx_sd_o | output | 1 | Delayed transmitter serial data to pad |
| pin_rx_ws_o | output | 1 | Delayed receiver word select to pad |
| pin_rx_bclk_o | output | 1 | Delayed receiver bit clock to pad |

## Verification
A delay code can change in the same cycle that an edge is still travelling through that path's delay line. The tap selection and the transport of the stored sample then act together.

The bench provokes this as follows. It sets the receiver data path to its longest code and sends a 0-to-1 step. It switches the code to the shortest value after the step has passed the first tap but before it reaches the last. The output must show the new value at once, not the old value or a cleared line.

On every delay measurement, the remaining control bits are random. This judges that changing a code or an order bit in the same word leaves the other paths alone.

// File: rtl/i2s_rt_pkg.sv
package i2s_rt_pkg;

  localparam int FLD_W      = 2;
  localparam int N_IN       = 6;
  localparam int N_OUT      = 5;
  localparam int CTRL_W     = 25;
  localparam int BIT_TX_ORD = 20;
  localparam int BIT_RX_ORD = 21;
  localparam int BIT_INV    = 24;
  localparam int OUT_BASE   = 10;

  // Input path index: 0 tx bclk, 1 tx ws, 2 rx bclk, 3 rx ws, 4 rx sd, 5 dvalid
  function automatic int in_lsb(input int idx);
    int r;
    case (idx)
      0: r = 0;
      1: r = 2;
      2: r = 4;
      3: r = 6;
      4: r = 8;
      default: r = 22;
    endcase
    return r;
  endfunction

  function automatic int in_ord_bit(input int idx);
    return (idx < 2) ? BIT_TX_ORD : BIT_RX_ORD;
  endfunction

  // Output path index: 0 tx bclk, 1 tx ws, 2 tx sd, 3 rx ws, 4 rx bclk
  function automatic int out_lsb(input int idx);
    return OUT_BASE + FLD_W * idx;
  endfunction

endpackage

// File: rtl/i2s_rt_rst_sync.sv
module i2s_rt_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/i2s_rt_in_path.sv
module i2s_rt_in_path #(
  parameter int DLY_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fall_first,
  input  logic [DLY_W-1:0] sel,
  input  logic             din,
  output logic             dout
);

  localparam int TAPS = 1 << DLY_W;

  // Rising-first pipeline: stage 1 on rising, stage 2 and line on falling.
  logic            r_s1_q;
  logic            r_s2_q;
  logic [TAPS-1:0] r_line_q;
  logic [TAPS-1:0] r_line_d;
  // Falling-first pipeline: stage 1 on falling, stage 2 and line on rising.
  logic            f_s1_q;
  logic            f_s2_q;
  logic [TAPS-1:0] f_line_q;
  logic [TAPS-1:0] f_line_d;

  always_comb begin
    r_line_d[0] = r_s2_q;
    f_line_d[0] = f_s2_q;
    for (int i = 1; i < TAPS; i++) begin
      r_line_d[i] = r_line_q[i-1];
      f_line_d[i] = f_line_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_s1_q   <= 1'b0;
      f_s2_q   <= 1'b0;
      f_line_q <= '0;
    end else begin
      r_s1_q   <= din;
      f_s2_q   <= f_s1_q;
      f_line_q <= f_line_d;
    end
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      f_s1_q   <= 1'b0;
      r_s2_q   <= 1'b0;
      r_line_q <= '0;
    end else begin
      f_s1_q   <= din;
      r_s2_q   <= r_s1_q;
      r_line_q <= r_line_d;
    end
  end

  assign dout = fall_first ? f_line_q[sel] : r_line_q[sel];

endmodule

// File: rtl/i2s_rt_out_path.sv
module i2s_rt_out_path #(
  parameter int DLY_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DLY_W-1:0] sel,
  input  logic             din,
  output logic             dout
);

  localparam int STAGES = (1 << DLY_W) - 1;

  logic [STAGES-1:0] line_q;
  logic [STAGES-1:0] line_d;
  logic [DLY_W-1:0]  tap_idx;

  always_comb begin
    line_d[0] = din;
    for (int i = 1; i < STAGES; i++) begin
      line_d[i] = line_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q <= '0;
    end else begin
      line_q <= line_d;
    end
  end

  assign tap_idx = sel - 1'b1;
  assign dout    = (sel == '0) ? din : line_q[tap_idx];

endmodule

// File: rtl/i2s_retime.sv
module i2s_retime
  import i2s_rt_pkg::*;
(
  input  logic              clk_ref,
  input  logic              rst_n,
  input  logic [CTRL_W-1:0] ctrl_word,
  input  logic              pin_tx_bclk_i,
  input  logic              pin_tx_ws_i,
  input  logic              pin_rx_bclk_i,
  input  logic              pin_rx_ws_i,
  input  logic              pin_rx_sd_i,
  input  logic              dvalid_i,
  output logic              core_tx_bclk_o,
  output logic              core_tx_ws_o,
  output logic              core_rx_bclk_o,
  output logic              core_rx_ws_o,
  output logic              core_rx_sd_o,
  output logic              dvalid_o,
  input  logic              core_tx_bclk_i,
  input  logic              core_tx_ws_i,
  input  logic              core_tx_sd_i,
  input  logic              core_rx_ws_i,
  input  logic              core_rx_bclk_i,
  output logic              pin_tx_bclk_o,
  output logic              pin_tx_ws_o,
  output logic              pin_tx_sd_o,
  output logic              pin_rx_ws_o,
  output logic              pin_rx_bclk_o
);

  logic             rst_core_n;
  logic [N_IN-1:0]  in_din;
  logic [N_IN-1:0]  in_dout;
  logic [N_OUT-1:0] out_din;
  logic [N_OUT-1:0] out_dout;

  i2s_rt_rst_sync u_rst (
    .clk        (clk_ref),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  assign in_din  = {dvalid_i, pin_rx_sd_i, pin_rx_ws_i,
                    pin_rx_bclk_i, pin_tx_ws_i, pin_tx_bclk_i};
  assign out_din = {core_rx_bclk_i, core_rx_ws_i, core_tx_sd_i,
                    core_tx_ws_i, core_tx_bclk_i};

  for (genvar g = 0; g < N_IN; g++) begin : g_in
    localparam int LSB = in_lsb(g);
    localparam int ORD = in_ord_bit(g);
    i2s_rt_in_path #(.DLY_W(FLD_W)) u_path (
      .clk        (clk_ref),
      .rst_n      (rst_core_n),
      .fall_first (ctrl_word[ORD]),
      .sel        (ctrl_word[LSB +: FLD_W]),
      .din        (in_din[g]),
      .dout       (in_dout[g])
    );
  end

  for (genvar g = 0; g < N_OUT; g++) begin : g_out
    localparam int LSB = out_lsb(g);
    i2s_rt_out_path #(.DLY_W(FLD_W)) u_path (
      .clk   (clk_ref),
      .rst_n (rst_core_n),
      .sel   (ctrl_word[LSB +: FLD_W]),
      .din   (out_din[g]),
      .dout  (out_dout[g])
    );
  end

  assign core_tx_bclk_o = in_dout[0] ^ ctrl_word[BIT_INV];
  assign core_tx_ws_o   = in_dout[1];
  assign core_rx_bclk_o = in_dout[2];
  assign core_rx_ws_o   = in_dout[3];
  assign core_rx_sd_o   = in_dout[4];
  assign dvalid_o       = in_dout[5];

  assign pin_tx_bclk_o  = out_dout[0];
  assign pin_tx_ws_o    = out_dout[1];
  assign pin_tx_sd_o    = out_dout[2];
  assign pin_rx_ws_o    = out_dout[3];
  assign pin_rx_bclk_o  = out_dout[4];

endmodule

// File: rtl/i2s_retime_chk.sv
module i2s_retime_chk (
  input logic        clk_ref,
  input logic        rst_n,
  input logic [24:0] ctrl_word,
  input logic        pin_rx_sd_i,
  input logic        core_rx_sd_o,
  input logic        core_tx_sd_i,
  input logic        pin_tx_sd_o
);

  logic [3:0] warm_cnt;
  logic       warm;

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) begin
      warm_cnt <= 4'd0;
    end else if (warm_cnt != 4'd15) begin
      warm_cnt <= warm_cnt + 4'd1;
    end
  end

  assign warm = (warm_cnt >= 4'd10);

  // Receiver data, rising-first: output seen at a rising edge equals the pad
  // value captured 2+c rising edges earlier, whatever the code history.
  AST_RXSD_IN_C0: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (warm && !ctrl_word[21] && ctrl_word[9:8] == 2'd0) |-> core_rx_sd_o == $past(pin_rx_sd_i, 2)); // R2
  AST_RXSD_IN_C1: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (warm && !ctrl_word[21] && ctrl_word[9:8] == 2'd1) |-> core_rx_sd_o == $past(pin_rx_sd_i, 3)); // R2
  AST_RXSD_IN_C2: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (warm && !ctrl_word[21] && ctrl_word[9:8] == 2'd2) |-> core_rx_sd_o == $past(pin_rx_sd_i, 4)); // R7
  AST_RXSD_IN_C3: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (warm && !ctrl_word[21] && ctrl_word[9:8] == 2'd3) |-> core_rx_sd_o == $past(pin_rx_sd_i, 5)); // R7

  AST_TXSD_OUT_C0: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (warm && ctrl_word[15:14] == 2'd0) |-> pin_tx_sd_o == core_tx_sd_i); // R5
  AST_TXSD_OUT_C1: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (warm && ctrl_word[15:14] == 2'd1) |-> pin_tx_sd_o == $past(core_tx_sd_i, 1)); // R5
  AST_TXSD_OUT_C2: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (warm && ctrl_word[15:14] == 2'd2) |-> pin_tx_sd_o == $past(core_tx_sd_i, 2)); // R5
  AST_TXSD_OUT_C3: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (warm && ctrl_word[15:14] == 2'd3) |-> pin_tx_sd_o == $past(core_tx_sd_i, 3)); // R5

endmodule

bind i2s_retime i2s_retime_chk u_chk (
  .clk_ref      (clk_ref),
  .rst_n        (rst_n),
  .ctrl_word    (ctrl_word),
  .pin_rx_sd_i  (pin_rx_sd_i),
  .core_rx_sd_o (core_rx_sd_o),
  .core_tx_sd_i (core_tx_sd_i),
  .pin_tx_sd_o  (pin_tx_sd_o)
);

// File: tb/i2s_retime_test.sv
`timescale 1ns/1ps
module i2s_retime_test;

  logic        clk_ref;
  logic        rst_n;
  logic [24:0] ctrl_word;
  logic [5:0]  pin_in;
  logic [4:0]  core_in;
  logic core_tx_bclk_o, core_tx_ws_o, core_rx_bclk_o, core_rx_ws_o, core_rx_sd_o, dvalid_o;
  logic pin_tx_bclk_o, pin_tx_ws_o, pin_tx_sd_o, pin_rx_ws_o, pin_rx_bclk_o;

  int n_tests;
  int n_fail;
  bit done;

  i2s_retime uut (
    .clk_ref        (clk_ref),
    .rst_n          (rst_n),
    .ctrl_word      (ctrl_word),
    .pin_tx_bclk_i  (pin_in[0]),
    .pin_tx_ws_i    (pin_in[1]),
    .pin_rx_bclk_i  (pin_in[2]),
    .pin_rx_ws_i    (pin_in[3]),
    .pin_rx_sd_i    (pin_in[4]),
    .dvalid_i       (pin_in[5]),
    .core_tx_bclk_o (core_tx_bclk_o),
    .core_tx_ws_o   (core_tx_ws_o),
    .core_rx_bclk_o (core_rx_bclk_o),
    .core_rx_ws_o   (core_rx_ws_o),
    .core_rx_sd_o   (core_rx_sd_o),
    .dvalid_o       (dvalid_o),
    .core_tx_bclk_i (core_in[0]),
    .core_tx_ws_i   (core_in[1]),
    .core_tx_sd_i   (core_in[2]),
    .core_rx_ws_i   (core_in[3]),
    .core_rx_bclk_i (core_in[4]),
    .pin_tx_bclk_o  (pin_tx_bclk_o),
    .pin_tx_ws_o    (pin_tx_ws_o),
    .pin_tx_sd_o    (pin_tx_sd_o),
    .pin_rx_ws_o    (pin_rx_ws_o),
    .pin_rx_bclk_o  (pin_rx_bclk_o)
  );

  initial begin
    clk_ref = 1'b0;
    forever #2.5 clk_ref = ~clk_ref;
  end

  // Paths 0..5 are input paths, 6..10 output paths.
  function automatic logic obs(input int p);
    case (p)
      0: return core_tx_bclk_o;
      1: return core_tx_ws_o;
      2: return core_rx_bclk_o;
      3: return core_rx_ws_o;
      4: return core_rx_sd_o;
      5: return dvalid_o;
      6: return pin_tx_bclk_o;
      7: return pin_tx_ws_o;
      8: return pin_tx_sd_o;
      9: return pin_rx_ws_o;
      default: return pin_rx_bclk_o;
    endcase
  endfunction

  function automatic int fld_lsb(input int p);
    case (p)
      0: return 0;
      1: return 2;
      2: return 4;
      3: return 6;
      4: return 8;
      5: return 22;
      default: return 10 + 2 * (p - 6);
    endcase
  endfunction

  function automatic int ord_bit(input int p);
    return (p < 2) ? 20 : 21;
  endfunction

  // Input toggles 1.25 ns after a rising edge and is observed 1 ns later, then
  // every 2.5 ns. Rising-first captures 3.75 ns later, falling-first 1.25 ns later;
  // adding (c+1.5) cycles gives the first observation step below.
  function automatic int exp_in_step(input int c, input int ord);
    return 2 * c + 5 - ord;
  endfunction

  // Code 0 is seen at step 0; code k changes on the k-th rising edge.
  function automatic int exp_out_step(input int k);
    return 2 * k;
  endfunction

  function automatic string req_of(input int p, input int ord);
    if (p == 5) return "R4";
    if (p >= 6) return "R5";
    return ord ? "R3" : "R2";
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic measure(input int p, input logic [24:0] cw, output int step);
    logic nv;
    logic ev;
    ctrl_word = cw;
    repeat (12) @(posedge clk_ref);
    @(posedge clk_ref);
    #1.25;
    if (p < 6) begin
      nv = ~pin_in[p];
      pin_in[p] = nv;
    end else begin
      nv = ~core_in[p-6];
      core_in[p-6] = nv;
    end
    ev = nv ^ ((p == 0) ? cw[24] : 1'b0);
    #1;
    step = -1;
    for (int h = 0; h < 20; h++) begin
      if (obs(p) == ev) begin
        step = h;
        break;
      end
      #2.5;
    end
  endtask

  task automatic run_case(input int p, input int c, input int ord, input logic [24:0] base,
                          input string tag);
    logic [24:0] cw;
    int st;
    int ex;
    cw = base;
    cw[fld_lsb(p) +: 2] = c[1:0];
    if (p < 6) cw[ord_bit(p)] = ord[0];
    measure(p, cw, st);
    ex = (p < 6) ? exp_in_step(c, ord) : exp_out_step(c);
    check(st == ex, tag, st, ex);
  endtask

  initial begin
    #500000;
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [24:0] rcw;
    int rp;
    n_tests = 0;
    n_fail  = 0;
    done    = 1'b0;
    rst_n     = 1'b0;
    ctrl_word = '0;
    pin_in    = '0;
    core_in   = '0;

    // R1: outputs during reset
    repeat (4) @(posedge clk_ref);
    #1.25;
    check({core_tx_bclk_o, core_tx_ws_o, core_rx_bclk_o, core_rx_ws_o, core_rx_sd_o, dvalid_o,
           pin_tx_bclk_o, pin_tx_ws_o, pin_tx_sd_o, pin_rx_ws_o, pin_rx_bclk_o} == 11'd0,
          "R1 in reset", 1, 0);
    rst_n = 1'b1;
    repeat (8) @(posedge clk_ref);
    #1.25;
    check({core_tx_bclk_o, core_tx_ws_o, core_rx_bclk_o, core_rx_ws_o, core_rx_sd_o, dvalid_o,
           pin_tx_bclk_o, pin_tx_ws_o, pin_tx_sd_o, pin_rx_ws_o, pin_rx_bclk_o} == 11'd0,
          "R1 after reset", 1, 0);

    // R6: inversion reaches only the transmitter bit clock, at once
    ctrl_word = 25'd1 << 24;
    #1;
    check(core_tx_bclk_o == 1'b1, "R6 invert bclk", core_tx_bclk_o, 1);
    check(core_tx_ws_o == 1'b0 && core_rx_bclk_o == 1'b0, "R6 others untouched",
          {core_tx_ws_o, core_rx_bclk_o}, 0);
    ctrl_word = '0;
    #1;
    check(core_tx_bclk_o == 1'b0, "R6 invert off", core_tx_bclk_o, 0);

    // Directed sweep: every path, every code, both orders on input paths
    for (int p = 0; p < 11; p++) begin
      for (int c = 0; c < 4; c++) begin
        if (p < 6) begin
          run_case(p, c, 0, 25'd0, req_of(p, 0));
          run_case(p, c, 1, 25'd0, req_of(p, 1));
        end else begin
          run_case(p, c, 0, 25'd0, req_of(p, 0));
        end
      end
    end

    // Inverted bit clock keeps the same timing
    run_case(0, 2, 1, 25'd1 << 24, "R6 timing");

    // R7: code change while a step travels the line (receiver data, rising first)
    pin_in[4] = 1'b0;
    ctrl_word = 25'd3 << 8;
    repeat (12) @(posedge clk_ref);
    @(posedge clk_ref);
    #1.25;
    pin_in[4] = 1'b1;
    #1;
    #15;
    check(core_rx_sd_o == 1'b0, "R7 step held at long tap", core_rx_sd_o, 0);
    ctrl_word = 25'd0;
    #0.5;
    check(core_rx_sd_o == 1'b1, "R7 step kept at short tap", core_rx_sd_o, 1);

    // R8: random codes with random unrelated control bits
    for (int n = 0; n < 150; n++) begin
      rcw = 25'($urandom(32'h5eed0000 + n));
      rp  = $urandom % 11;
      run_case(rp, $urandom % 4, $urandom % 2, rcw, {"R8 ", req_of(rp, 0)});
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule